// File: doc/BRIEF.md
# Cascaded Serial Latch-Command Receiver

This block receives grayscale and control data on a two-wire serial link: a data line and a separate data clock. Each rising data-clock edge pushes one bit into a wide shift register. The bit pushed out of the far end is passed on to the next device in a daisy chain, so several drivers can share one link. The data clock is also passed on.

No dedicated pin carries the latch command. Instead, the sender holds the data clock still, at either level, for a long quiet interval and then toggles the data line a set number of times. The receiver watches both pins with an oversampling system clock. It times the quiet interval and qualifies each data-line pulse against minimum high and low widths. On the second qualified falling edge it copies the shift register into a holding latch.

While a command is in progress, the forwarded data line carries fixed-width pulses regenerated locally. This keeps the duty ratio from drifting along a long chain. After the last pulse a hold-off scaled by chain depth blocks any new command. All timing limits are counted in system-clock cycles and set by parameters.

Top module: `latch_cmd_rx`

## Requirements
- R1: After reset, latch_strobe, cmd_word, gs_words and dout_fwd are all 0.
- R2: In shifting mode, each rising edge of dck_in shifts the level of din_in into the least significant end of the shift register. dout_fwd shows the most significant bit, which is the oldest one, so a bit reappears on dout_fwd W rising edges after it entered, where W = CMD_BITS + CHANNELS*GS_BITS. dck_fwd follows dck_in after synchronization.
- R3: A command becomes armed only once the synchronized data clock has had no edge for IDLE_CYC system cycles. The level held during that interval, high or low, does not matter. Pulses sent before the receiver is armed are not counted.
- R4: Once armed, a burst of four qualified data-line pulses forms one command. The latch takes the shift register contents on the second qualified falling edge. latch_strobe is high for exactly one cycle, once per command.
- R5: A pulse is qualified only if its high phase lasts at least HI_MIN_CYC cycles and the low phase before it lasts at least LO_MIN_CYC cycles. An unqualified pulse is not counted, and it does not end the command.
- R6: In command mode, every rising edge of the data line makes dout_fwd go high for exactly RETIME_CYC cycles, whatever the input pulse width.
- R7: Any data-clock edge while armed or during the burst ends the command. If this happens before the second qualified fall, the latch keeps its old contents. Shifting then continues normally.
- R8: After the fourth qualified fall, a hold-off of STOP_BASE_CYC + CASCADE_DEPTH*STOP_STEP_CYC cycles follows. Pulses during the hold-off are not counted. A new command then needs a fresh quiet interval.
- R9: cmd_word is the top CMD_BITS bits of the latch, which are the bits shifted in first. Channel k's grayscale word sits at gs_words[k*GS_BITS +: GS_BITS], and channel 0 holds the last bits shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dck_in | input | 1 | Serial data clock from upstream |
| din_in | input | 1 | Serial data line from upstream |
| dck_fwd | output | 1 | Data clock passed on downstream |
| dout_fwd | output | 1 | Oldest shift bit, or a regenerated command pulse, passed downstream |
| latch_strobe | output | 1 | One-cycle pulse when the latch is loaded |
| cmd_word | output | CMD_BITS | Latched command word |
| gs_words | output | CHANNELS*GS_BITS | Latched grayscale words, channel 0 at the bottom |

## Verification
The hardest states to reach are the narrow margins around each width limit. A pulse that is one cycle too short must be dropped, while a command must still complete at the exact threshold. The bench drives the pins on a small configuration and sweeps the high width, and separately the preceding low width, across their limits. For each width it checks whether the following good pulse produces the latch strobe. Further sequences abort a burst with a stray clock edge, arm with the clock parked high, and send pulses inside and just after the hold-off.

// File: rtl/lcr_pkg.sv
`timescale 1ns/1ps
package lcr_pkg;
   typedef enum logic [1:0] {
      RX_SHIFT = 2'd0,
      RX_CMD   = 2'd1,
      RX_HOLD  = 2'd2
   } rx_state_e;

   // command burst length and the qualified fall that loads the latch
   localparam int CMD_PULSES = 4;
   localparam int LOAD_AT    = 2;
endpackage

// File: rtl/lcr_sync.sv
`timescale 1ns/1ps
module lcr_sync #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q <= '0;
         else        stage_q <= {stage_q[0], async_in[i]};
      end
      assign sync_out[i] = stage_q[1];
   end
endmodule

// File: rtl/lcr_shifter.sv
`timescale 1ns/1ps
module lcr_shifter #(
   parameter int W = 208
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (shift_en) data_q <= {data_q[W-2:0], bit_in};
   end
endmodule

// File: rtl/lcr_cmd_fsm.sv
`timescale 1ns/1ps
module lcr_cmd_fsm import lcr_pkg::*; #(
   parameter int IDLE_CYC   = 44000,
   parameter int HI_MIN_CYC = 14,
   parameter int LO_MIN_CYC = 46,
   parameter int STOP_CYC   = 42
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dck_edge,
   input  logic din_lvl,
   input  logic din_rise,
   input  logic din_fall,
   output logic load_now,
   output logic in_cmd
);
   localparam int IW = $clog2(IDLE_CYC + 1);
   localparam int HW = $clog2(HI_MIN_CYC + 1);
   localparam int LW = $clog2(LO_MIN_CYC + 1);
   localparam int SW = $clog2(STOP_CYC + 1);
   localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);
   localparam logic [HW-1:0] HI_SAT    = HW'(HI_MIN_CYC);
   localparam logic [LW-1:0] LO_SAT    = LW'(LO_MIN_CYC);
   localparam logic [SW-1:0] STOP_LAST = SW'(STOP_CYC - 1);
   localparam logic [1:0]    LOAD_IDX  = 2'(LOAD_AT - 1);
   localparam logic [1:0]    LAST_IDX  = 2'(CMD_PULSES - 1);

   rx_state_e       state_q;
   logic [IW-1:0]   idle_q;
   logic [SW-1:0]   hold_q;
   logic [HW-1:0]   hi_q;
   logic [LW-1:0]   lo_q;
   logic [1:0]      pcnt_q;
   logic            pend_q;
   logic            fall_ok;

   assign fall_ok  = din_fall && pend_q && (hi_q == HI_SAT);
   assign in_cmd   = (state_q != RX_SHIFT);
   assign load_now = (state_q == RX_CMD) && !dck_edge && fall_ok && (pcnt_q == LOAD_IDX);

   // phase width meters, saturating at their thresholds
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (din_rise)                   hi_q <= HW'(1);
         else if (din_lvl && hi_q != HI_SAT) hi_q <= hi_q + HW'(1);
         if (din_fall)                   lo_q <= LW'(1);
         else if (!din_lvl && lo_q != LO_SAT) lo_q <= lo_q + LW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_SHIFT;
         idle_q  <= '0;
         hold_q  <= '0;
         pcnt_q  <= '0;
         pend_q  <= 1'b0;
      end else begin
         case (state_q)
            RX_SHIFT: begin
               if (dck_edge) idle_q <= '0;
               else if (idle_q == IDLE_LAST) begin
                  state_q <= RX_CMD;
                  pcnt_q  <= '0;
                  pend_q  <= 1'b0;
               end else idle_q <= idle_q + IW'(1);
            end
            RX_CMD: begin
               if (dck_edge) begin
                  state_q <= RX_SHIFT;
                  idle_q  <= '0;
               end else begin
                  if (din_rise) pend_q <= (lo_q == LO_SAT);
                  if (din_fall) begin
                     pend_q <= 1'b0;
                     if (fall_ok) begin
                        pcnt_q <= pcnt_q + 2'd1;
                        if (pcnt_q == LAST_IDX) begin
                           state_q <= RX_HOLD;
                           hold_q  <= '0;
                        end
                     end
                  end
               end
            end
            RX_HOLD: begin
               if (dck_edge || hold_q == STOP_LAST) begin
                  state_q <= RX_SHIFT;
                  idle_q  <= '0;
               end else hold_q <= hold_q + SW'(1);
            end
            default: state_q <= RX_SHIFT;
         endcase
      end
   end
endmodule

// File: rtl/lcr_retimer.sv
`timescale 1ns/1ps
module lcr_retimer #(
   parameter int RETIME_CYC = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);
   localparam int RW = $clog2(RETIME_CYC + 1);
   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (trig && cnt_q == '0) cnt_q <= RW'(RETIME_CYC);
      else if (cnt_q != '0)         cnt_q <= cnt_q - RW'(1);
   end
   assign pulse = (cnt_q != '0);
endmodule

// File: rtl/latch_cmd_rx.sv
`timescale 1ns/1ps
module latch_cmd_rx #(
   parameter int CHANNELS      = 12,
   parameter int GS_BITS       = 16,
   parameter int CMD_BITS      = 16,
   parameter int IDLE_CYC      = 44000,
   parameter int HI_MIN_CYC    = 14,
   parameter int LO_MIN_CYC    = 46,
   parameter int RETIME_CYC    = 18,
   parameter int STOP_BASE_CYC = 40,
   parameter int STOP_STEP_CYC = 2,
   parameter int CASCADE_DEPTH = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dck_in,
   input  logic                          din_in,
   output logic                          dck_fwd,
   output logic                          dout_fwd,
   output logic                          latch_strobe,
   output logic [CMD_BITS-1:0]           cmd_word,
   output logic [CHANNELS*GS_BITS-1:0]   gs_words
);
   localparam int GS_TOTAL = CHANNELS * GS_BITS;
   localparam int W_TOTAL  = CMD_BITS + GS_TOTAL;
   localparam int STOP_CYC = STOP_BASE_CYC + CASCADE_DEPTH * STOP_STEP_CYC;

   if (CHANNELS < 1 || GS_BITS < 1 || CMD_BITS < 1) begin : g_bad_width
      $error("latch_cmd_rx: channel, grayscale and command widths must be positive");
   end
   if (IDLE_CYC < 2 || HI_MIN_CYC < 1 || LO_MIN_CYC < 1) begin : g_bad_timing
      $error("latch_cmd_rx: timing thresholds out of range");
   end
   if (RETIME_CYC < 1 || STOP_CYC < 1) begin : g_bad_pulse
      $error("latch_cmd_rx: retime width and hold-off must be at least one cycle");
   end

   logic [1:0]         pin_s, pin_prev;
   logic               dck_edge, dck_rise, din_rise, din_fall;
   logic [W_TOTAL-1:0] shift_q, latch_q;
   logic               load_now, in_cmd, rt_pulse;

   // bit 0 carries the data clock, bit 1 the data line
   lcr_sync #(.WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in({din_in, dck_in}), .sync_out(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= '0;
      else        pin_prev <= pin_s;
   end

   assign dck_edge = pin_s[0] ^ pin_prev[0];
   assign dck_rise = pin_s[0] & ~pin_prev[0];
   assign din_rise = pin_s[1] & ~pin_prev[1];
   assign din_fall = ~pin_s[1] & pin_prev[1];

   lcr_shifter #(.W(W_TOTAL)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(dck_rise), .bit_in(pin_s[1]), .data_q(shift_q)
   );

   lcr_cmd_fsm #(
      .IDLE_CYC(IDLE_CYC), .HI_MIN_CYC(HI_MIN_CYC),
      .LO_MIN_CYC(LO_MIN_CYC), .STOP_CYC(STOP_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .dck_edge(dck_edge), .din_lvl(pin_s[1]),
      .din_rise(din_rise), .din_fall(din_fall), .load_now(load_now), .in_cmd(in_cmd)
   );

   lcr_retimer #(.RETIME_CYC(RETIME_CYC)) u_rt (
      .clk(clk), .rst_n(rst_n), .trig(in_cmd & din_rise), .pulse(rt_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q      <= '0;
         latch_strobe <= 1'b0;
      end else begin
         latch_strobe <= load_now;
         if (load_now) latch_q <= shift_q;
      end
   end

   assign dck_fwd  = pin_s[0];
   assign dout_fwd = in_cmd ? rt_pulse : shift_q[W_TOTAL-1];
   assign cmd_word = latch_q[W_TOTAL-1 -: CMD_BITS];
   assign gs_words = latch_q[GS_TOTAL-1:0];
endmodule

// File: rtl/latch_cmd_rx_chk.sv
`timescale 1ns/1ps
module latch_cmd_rx_chk #(
   parameter int LATCH_W    = 208,
   parameter int IDLE_CYC   = 44000,
   parameter int RETIME_CYC = 18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dck_fwd,
   input logic               dout_fwd,
   input logic               latch_strobe,
   input logic               in_cmd,
   input logic [LATCH_W-1:0] latch_bus
);
   localparam int IW = $clog2(IDLE_CYC + 1);
   localparam int RW = $clog2(RETIME_CYC + 2);
   localparam logic [IW-1:0] QUIET_SAT = IW'(IDLE_CYC);
   localparam logic [RW-1:0] RUN_SAT   = RW'(RETIME_CYC + 1);

   logic [IW-1:0] quiet_q;
   logic [RW-1:0] hi_run_q;
   logic          dck_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q    <= '0;
         hi_run_q   <= '0;
         dck_last_q <= 1'b0;
      end else begin
         dck_last_q <= dck_fwd;
         if (dck_fwd != dck_last_q)   quiet_q <= '0;
         else if (quiet_q != QUIET_SAT) quiet_q <= quiet_q + IW'(1);
         if (!(in_cmd && dout_fwd))   hi_run_q <= '0;
         else if (hi_run_q != RUN_SAT) hi_run_q <= hi_run_q + RW'(1);
      end
   end

   a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      latch_strobe |=> !latch_strobe);

   a_r4_strobe_in_command: assert property (@(posedge clk) disable iff (!rst_n)
      latch_strobe |-> in_cmd);

   a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_strobe |-> $stable(latch_bus));

   a_r3_arm_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_cmd) |-> (quiet_q >= IW'(IDLE_CYC - 1)));

   a_r6_retime_width: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cmd && dout_fwd) |-> (hi_run_q < RW'(RETIME_CYC)));
endmodule

bind latch_cmd_rx latch_cmd_rx_chk #(
   .LATCH_W(W_TOTAL), .IDLE_CYC(IDLE_CYC), .RETIME_CYC(RETIME_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dck_fwd(dck_fwd), .dout_fwd(dout_fwd),
   .latch_strobe(latch_strobe), .in_cmd(in_cmd), .latch_bus(latch_q)
);

// File: tb/latch_cmd_rx_bench.sv
`timescale 1ns/1ps
module latch_cmd_rx_bench;
   localparam int CH = 2, GSB = 4, CMB = 4;
   localparam int W = CMB + CH * GSB;
   localparam int IDLE = 60, HI = 4, LO = 6, RT = 3, SB = 8, SS = 2, CD = 3;
   localparam int HOLD = SB + SS * CD;

   logic clk = 1'b0, rst_n = 1'b0, dck = 1'b0, din = 1'b0;
   logic dck_fwd, dout_fwd, latch_strobe;
   logic [CMB-1:0]    cmd_word;
   logic [CH*GSB-1:0] gs_words;

   int tests = 0, fails = 0, strobes = 0, runs = 0, run_len = 0;
   bit meas_on = 1'b0, run_live = 1'b0, prev_dout = 1'b0;

   always #2.5 clk = ~clk;

   latch_cmd_rx #(
      .CHANNELS(CH), .GS_BITS(GSB), .CMD_BITS(CMB), .IDLE_CYC(IDLE),
      .HI_MIN_CYC(HI), .LO_MIN_CYC(LO), .RETIME_CYC(RT),
      .STOP_BASE_CYC(SB), .STOP_STEP_CYC(SS), .CASCADE_DEPTH(CD)
   ) u_latch_cmd_rx (
      .clk(clk), .rst_n(rst_n), .dck_in(dck), .din_in(din), .dck_fwd(dck_fwd),
      .dout_fwd(dout_fwd), .latch_strobe(latch_strobe), .cmd_word(cmd_word),
      .gs_words(gs_words)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // strobe counter and R6 pulse-width monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && latch_strobe) strobes++;
      if (meas_on) begin
         if (dout_fwd && !prev_dout) begin run_live = 1'b1; run_len = 1; end
         else if (dout_fwd && run_live) run_len++;
         else if (!dout_fwd && prev_dout && run_live) begin
            runs++;
            check(run_len == RT, "R6 retimed width", run_len, RT);
            run_live = 1'b0;
         end
      end else run_live = 1'b0;
      prev_dout = dout_fwd;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit b, input bit leave_high);
      din = b;
      wait_cyc(3);
      dck = 1'b1;
      wait_cyc(4);
      if (!leave_high) begin
         dck = 1'b0;
         wait_cyc(4);
      end
   endtask

   // shifts w in MSB first; optionally checks R2 forwarding against the previous word
   task automatic send_word(input logic [W-1:0] w, input logic [W-1:0] prev, input bit chk);
      logic [2*W-1:0] comb;
      comb = {prev, w};
      for (int t = 1; t <= W; t++) begin
         send_bit(w[W-t], 1'b0);
         if (chk) check(dout_fwd == comb[2*W-1-t], "R2 forwarded bit", dout_fwd, comb[2*W-1-t]);
      end
      din = 1'b0;
   endtask

   task automatic pulse(input int h, input int l);
      din = 1'b1;
      wait_cyc(h);
      din = 1'b0;
      wait_cyc(l);
   endtask

   task automatic check_latch(input logic [W-1:0] w, input string req);
      check(cmd_word == w[W-1 -: CMB], req, cmd_word, w[W-1 -: CMB]);
      check(gs_words == w[CH*GSB-1:0], req, gs_words, w[CH*GSB-1:0]);
   endtask

   // full command: R4 load on second fall, R6 retimed pulses, R8 hold-off wait
   task automatic full_latch(input logic [W-1:0] w);
      int s0;
      wait_cyc(IDLE + 8);
      s0 = strobes;
      runs = 0;
      meas_on = 1'b1;
      pulse(6, 8);
      check(strobes == s0, "R4 no load after first fall", strobes, s0);
      pulse(6, 8);
      check(strobes == s0 + 1, "R4 load on second fall", strobes, s0 + 1);
      check_latch(w, "R9 latch mapping");
      pulse(6, 8);
      pulse(6, 8);
      check(strobes == s0 + 1, "R4 single strobe per command", strobes, s0 + 1);
      wait_cyc(HOLD + 6);
      meas_on = 1'b0;
      check(runs == 4, "R6 one retimed pulse per input pulse", runs, 4);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [W-1:0] prev, w, a, c;
      int s0;
      wait_cyc(6);
      rst_n = 1'b1;
      wait_cyc(2);
      check(latch_strobe == 1'b0, "R1 strobe after reset", latch_strobe, 0);
      check(cmd_word == '0, "R1 cmd after reset", cmd_word, 0);
      check(gs_words == '0, "R1 gs after reset", gs_words, 0);
      check(dout_fwd == 1'b0, "R1 dout after reset", dout_fwd, 0);

      // R2 / R9 / R4 sweep over word patterns
      prev = '0;
      for (int k = 0; k < 6; k++) begin
         w = W'((k * 12'h3A5) ^ 12'h5C3 ^ (k << 9));
         send_word(w, prev, 1'b1);
         full_latch(w);
         prev = w;
      end

      // R3: arm with the data clock parked high
      w = 12'hA5C;
      for (int t = 1; t < W; t++) send_bit(w[W-t], 1'b0);
      send_bit(w[0], 1'b1);
      din = 1'b0;
      wait_cyc(4);
      check(dck_fwd == 1'b1, "R2 clock forwarded high", dck_fwd, 1);
      full_latch(w);
      check_latch(w, "R3 armed at high level");
      dck = 1'b0;
      wait_cyc(4);
      check(dck_fwd == 1'b0, "R2 clock forwarded low", dck_fwd, 0);

      // R3: too short a quiet interval does not arm
      send_word(12'h0F0, '0, 1'b0);
      wait_cyc(2);
      s0 = strobes;
      pulse(6, 8);
      pulse(6, 8);
      check(strobes == s0, "R3 short quiet not armed", strobes, s0);
      send_bit(1'b0, 1'b0);

      // R5: sweep high width across the limit
      for (int h = 1; h <= HI + 1; h++) begin
         w = W'(12'h135 + h * 12'h111);
         send_word(w, '0, 1'b0);
         wait_cyc(IDLE + 8);
         s0 = strobes;
         pulse(h, 8);
         pulse(6, 8);
         check(strobes - s0 == ((h >= HI) ? 1 : 0), "R5 high width qualification",
               strobes - s0, (h >= HI) ? 1 : 0);
         if (h >= HI) check_latch(w, "R5 latch after qualified pulses");
      end

      // R5: sweep preceding low width across the limit
      for (int l = 1; l <= LO + 1; l++) begin
         w = W'(12'hC21 ^ (l * 12'h0B3));
         send_word(w, '0, 1'b0);
         wait_cyc(IDLE + 8);
         s0 = strobes;
         pulse(6, l);
         pulse(6, 8);
         check(strobes - s0 == ((l >= LO) ? 1 : 0), "R5 low width qualification",
               strobes - s0, (l >= LO) ? 1 : 0);
      end

      // R7: abort by a data-clock edge after one qualified pulse
      a = 12'h6D9;
      send_word(a, '0, 1'b0);
      full_latch(a);
      send_word(12'h924, '0, 1'b0);
      wait_cyc(IDLE + 8);
      s0 = strobes;
      pulse(6, 8);
      send_bit(1'b1, 1'b0);
      pulse(6, 8);
      pulse(6, 8);
      pulse(6, 8);
      check(strobes == s0, "R7 aborted command no strobe", strobes, s0);
      check_latch(a, "R7 latch unchanged after abort");
      c = 12'h3E7;
      send_word(c, '0, 1'b0);
      full_latch(c);
      check_latch(c, "R7 shifting resumes after abort");

      // R8: pulses inside and right after the hold-off are not counted
      send_word(c, c, 1'b1);
      wait_cyc(IDLE + 8);
      s0 = strobes;
      for (int p = 0; p < 4; p++) pulse(6, 8);
      for (int p = 0; p < 4; p++) pulse(6, 8);
      check(strobes == s0 + 1, "R8 no count in hold-off or before fresh quiet", strobes, s0 + 1);
      wait_cyc(IDLE + 8);
      pulse(6, 8);
      pulse(6, 8);
      check(strobes == s0 + 2, "R8 rearmed after fresh quiet", strobes, s0 + 2);
      check_latch(c, "R8 latch value after rearm");
      pulse(6, 8);
      pulse(6, 8);
      wait_cyc(HOLD + 6);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule